// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This controller resolves read-after-write hazards for a five-stage in-order pipeline. The stages run in this order: fetch, decode, operand fetch, execute, write back. Each cycle it looks at the instruction sitting in operand fetch and at the two older instructions in execute and write back. For each source operand it drives a select for the operand multiplexer. The select picks the register file, the execute-stage ALU result, or the write-back value, which also carries data returning from a load.

When a bypass cannot supply a value in time, the controller raises a stall. The stall freezes the program counter, the fetch, decode and operand-fetch registers. At the same time it asks for a bubble with all write enables cleared to be placed into execute. There are two such cases: a load in execute feeding the operand-fetch instruction, and a register-file read in operand fetch colliding with a write on the register file's single shared port. A busy multi-cycle execute unit holds the whole front of the pipeline, including execute itself.

The controller keeps its own copy of the destination, write-enable and load flag of the execute and write-back slots. It advances this copy from the operand-fetch fields exactly as the datapath pipeline registers advance.

Top module: `raw_bypass_ctl`

## Requirements
- R1: Reset empties both tracked slots. With reset asserted, and in the first cycle after it, every select reads 00 and neither stall nor bubble is raised, whatever the operand-fetch instruction is.
- R2: A used, nonzero source equal to the destination of a writing instruction in execute gets select 01 (execute result).
- R3: A used, nonzero source equal to the destination of a writing instruction in write back, and not matched in execute, gets select 10 (write-back or load data).
- R4: When both the execute and the write-back instruction write the source register, the younger execute producer wins and the select is 01.
- R5: Register 0 never creates a dependency. A source of 0 keeps select 00, and a write back to register 0 occupies no register-file port.
- R6: An operand whose use flag is low keeps select 00 and causes no stall, even if its register number matches an older producer.
- R7: A used source matched by a load in execute raises stall and bubble. In the next cycle, with the same instruction held, that source selects 10 and no stall is raised.
- R8: When write back writes a nonzero register and some used, nonzero source must be read from the register file (not forwarded), stall and bubble are raised.
- R9: While the multi-cycle busy input is high, stall is 1 and bubble is 0. The execute slot keeps its instruction and the write-back slot becomes empty.
- R10: Without a stall, the operand-fetch instruction becomes the execute producer on the next cycle and the write-back producer on the cycle after.
- R11: In the cycle after a bubble, no operand is forwarded from execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| of_use_a_i | input | 1 | Operand A is read by the operand-fetch instruction |
| of_src_a_i | input | REG_W | Source register of operand A |
| of_use_b_i | input | 1 | Operand B is read by the operand-fetch instruction |
| of_src_b_i | input | REG_W | Source register of operand B |
| of_wr_i | input | 1 | Operand-fetch instruction writes a register |
| of_ld_i | input | 1 | Operand-fetch instruction is a load |
| of_dst_i | input | REG_W | Destination register of the operand-fetch instruction |
| mc_busy_i | input | 1 | Multi-cycle execute unit is busy |
| sel_a_o | output | 2 | Operand A select: 00 register file, 01 execute, 10 write back |
| sel_b_o | output | 2 | Operand B select, same encoding |
| stall_o | output | 1 | Freeze PC, fetch, decode and operand fetch |
| bubble_o | output | 1 | Load an empty instruction into execute |

## Verification
The bench builds the controller with its default five-bit register number. That width reaches register 0 as well as ordinary registers, so the rule that register 0 is never a dependency is tested on both sources and on destinations. One walk through an instruction stream reaches every pairing of producer slot and source: matches in execute only, write back only, both slots at once, loads in execute and then in write back, a port clash held for two cycles in a row, and a busy window that empties write back while execute keeps its producer. A directed test then applies reset while a producer is in flight.

// File: rtl/raw_bypass_pkg.sv
package raw_bypass_pkg;

    // Operand multiplexer select codes
    typedef enum logic [1:0] {
        ROUTE_RF = 2'b00,
        ROUTE_EX = 2'b01,
        ROUTE_WB = 2'b10
    } route_e;

endpackage

// File: rtl/rbc_src_route.sv
module rbc_src_route
    import raw_bypass_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_i,
    input  logic [REG_W-1:0] src_i,
    input  logic             ex_wr_i,
    input  logic             ex_ld_i,
    input  logic [REG_W-1:0] ex_dst_i,
    input  logic             wb_wr_i,
    input  logic [REG_W-1:0] wb_dst_i,
    output route_e           route_o,
    output logic             need_rf_o,
    output logic             load_wait_o
);

    logic src_live;
    logic ex_hit;
    logic wb_hit;

    always_comb begin
        src_live    = use_i && (src_i != '0);
        ex_hit      = src_live && ex_wr_i && (ex_dst_i == src_i);
        wb_hit      = src_live && wb_wr_i && (wb_dst_i == src_i);
        // the younger producer in execute has priority
        if (ex_hit) begin
            route_o = ROUTE_EX;
        end else if (wb_hit) begin
            route_o = ROUTE_WB;
        end else begin
            route_o = ROUTE_RF;
        end
        need_rf_o   = src_live && !ex_hit && !wb_hit;
        load_wait_o = ex_hit && ex_ld_i;
    end

    // R5 R6
    src_zero_or_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_i || (src_i == '0)) |-> (route_o == ROUTE_RF) && !load_wait_o && !need_rf_o);

    // R4
    ex_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_o == ROUTE_EX) |-> ex_wr_i && (ex_dst_i == src_i));

    // R3
    wb_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_o == ROUTE_WB) |-> wb_wr_i && (wb_dst_i == src_i));

endmodule

// File: rtl/rbc_stage_track.sv
module rbc_stage_track #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             flush_i,
    input  logic             in_wr_i,
    input  logic             in_ld_i,
    input  logic [REG_W-1:0] in_dst_i,
    output logic             ex_wr_o,
    output logic             ex_ld_o,
    output logic [REG_W-1:0] ex_dst_o,
    output logic             wb_wr_o,
    output logic [REG_W-1:0] wb_dst_o
);

    typedef struct packed {
        logic             wr;
        logic             ld;
        logic [REG_W-1:0] dst;
    } ex_slot_t;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] dst;
    } wb_slot_t;

    typedef struct packed {
        ex_slot_t ex;
        wb_slot_t wb;
    } track_t;

    track_t   st_d, st_q;
    ex_slot_t in_slot;

    always_comb begin
        in_slot.wr  = in_wr_i;
        in_slot.ld  = in_ld_i;
        in_slot.dst = in_dst_i;
        st_d        = st_q;
        if (hold_i) begin
            // execute keeps its instruction, write back receives an empty slot
            st_d.ex = st_q.ex;
            st_d.wb = '0;
        end else begin
            st_d.wb.wr  = st_q.ex.wr;
            st_d.wb.dst = st_q.ex.dst;
            st_d.ex     = flush_i ? '0 : in_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_wr_o  = st_q.ex.wr;
    assign ex_ld_o  = st_q.ex.ld;
    assign ex_dst_o = st_q.ex.dst;
    assign wb_wr_o  = st_q.wb.wr;
    assign wb_dst_o = st_q.wb.dst;

    // R9
    busy_holds_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.ex == $past(st_q.ex)) && !st_q.wb.wr);

    // R10
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !flush_i) |=> (st_q.ex == $past(in_slot)));

endmodule

// File: rtl/raw_bypass_ctl.sv
module raw_bypass_ctl
    import raw_bypass_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             of_use_a_i,
    input  logic [REG_W-1:0] of_src_a_i,
    input  logic             of_use_b_i,
    input  logic [REG_W-1:0] of_src_b_i,
    input  logic             of_wr_i,
    input  logic             of_ld_i,
    input  logic [REG_W-1:0] of_dst_i,
    input  logic             mc_busy_i,
    output logic [1:0]       sel_a_o,
    output logic [1:0]       sel_b_o,
    output logic             stall_o,
    output logic             bubble_o
);

    localparam int NUM_SRC = 2;

    logic             ex_wr;
    logic             ex_ld;
    logic [REG_W-1:0] ex_dst;
    logic             wb_wr;
    logic [REG_W-1:0] wb_dst;

    logic             use_arr [NUM_SRC];
    logic [REG_W-1:0] src_arr [NUM_SRC];
    route_e           route_arr [NUM_SRC];
    logic [NUM_SRC-1:0] need_rf;
    logic [NUM_SRC-1:0] load_wait;

    logic load_use;
    logic port_clash;
    logic hazard;

    assign use_arr[0] = of_use_a_i;
    assign src_arr[0] = of_src_a_i;
    assign use_arr[1] = of_use_b_i;
    assign src_arr[1] = of_src_b_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        rbc_src_route #(.REG_W(REG_W)) u_route (
            .clk         (clk),
            .rst_n       (rst_n),
            .use_i       (use_arr[g]),
            .src_i       (src_arr[g]),
            .ex_wr_i     (ex_wr),
            .ex_ld_i     (ex_ld),
            .ex_dst_i    (ex_dst),
            .wb_wr_i     (wb_wr),
            .wb_dst_i    (wb_dst),
            .route_o     (route_arr[g]),
            .need_rf_o   (need_rf[g]),
            .load_wait_o (load_wait[g])
        );
    end

    always_comb begin
        load_use   = |load_wait;
        // a write to register 0 is discarded and takes no port
        port_clash = wb_wr && (wb_dst != '0) && (|need_rf);
        hazard     = load_use || port_clash;
        stall_o    = mc_busy_i || hazard;
        bubble_o   = !mc_busy_i && hazard;
        sel_a_o    = route_arr[0];
        sel_b_o    = route_arr[1];
    end

    rbc_stage_track #(.REG_W(REG_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (mc_busy_i),
        .flush_i  (bubble_o),
        .in_wr_i  (of_wr_i),
        .in_ld_i  (of_ld_i),
        .in_dst_i (of_dst_i),
        .ex_wr_o  (ex_wr),
        .ex_ld_o  (ex_ld),
        .ex_dst_o (ex_dst),
        .wb_wr_o  (wb_wr),
        .wb_dst_o (wb_dst)
    );

    // R11
    bubble_empties_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> !ex_wr && (sel_a_o != ROUTE_EX) && (sel_b_o != ROUTE_EX));

    // R7 R8 R9
    stall_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (mc_busy_i != bubble_o));

endmodule

// File: tb/raw_bypass_ctl_test.sv
module raw_bypass_ctl_test;

    localparam int REG_W = 5;
    localparam int NVEC  = 21;

    typedef struct packed {
        logic       busy;
        logic       ua;
        logic [4:0] sa;
        logic       ub;
        logic [4:0] sb;
        logic       wr;
        logic       ld;
        logic [4:0] dst;
        logic [1:0] ea;
        logic [1:0] eb;
        logic       es;
        logic       eu;
        logic [7:0] req;
    } vec_t;

    // one row per cycle; expected outputs during that cycle
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 5'd1,  1'b1, 5'd2,  1'b1, 1'b0, 5'd3,  2'b00, 2'b00, 1'b0, 1'b0, 8'd1 },  // R1 empty slots
        '{1'b0, 1'b1, 5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 5'd5,  2'b01, 2'b00, 1'b0, 1'b0, 8'd2 },  // R2
        '{1'b0, 1'b1, 5'd3,  1'b1, 5'd5,  1'b0, 1'b0, 5'd0,  2'b10, 2'b01, 1'b0, 1'b0, 8'd3 },  // R3
        '{1'b0, 1'b1, 5'd5,  1'b1, 5'd0,  1'b1, 1'b0, 5'd5,  2'b10, 2'b00, 1'b0, 1'b0, 8'd5 },  // R5 src 0
        '{1'b0, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 5'd5,  2'b00, 2'b00, 1'b0, 1'b0, 8'd5 },  // R5
        '{1'b0, 1'b1, 5'd5,  1'b1, 5'd5,  1'b1, 1'b0, 5'd0,  2'b01, 2'b01, 1'b0, 1'b0, 8'd4 },  // R4
        '{1'b0, 1'b1, 5'd0,  1'b1, 5'd5,  1'b0, 1'b0, 5'd0,  2'b00, 2'b10, 1'b0, 1'b0, 8'd5 },  // R5 write r0
        '{1'b0, 1'b1, 5'd9,  1'b0, 5'd0,  1'b1, 1'b1, 5'd7,  2'b00, 2'b00, 1'b0, 1'b0, 8'd5 },  // R5 no port
        '{1'b0, 1'b1, 5'd7,  1'b0, 5'd7,  1'b1, 1'b0, 5'd8,  2'b01, 2'b00, 1'b1, 1'b1, 8'd7 },  // R7 R6
        '{1'b0, 1'b1, 5'd7,  1'b0, 5'd7,  1'b1, 1'b0, 5'd8,  2'b10, 2'b00, 1'b0, 1'b0, 8'd11},  // R11 R7
        '{1'b0, 1'b1, 5'd2,  1'b1, 5'd8,  1'b1, 1'b1, 5'd9,  2'b00, 2'b01, 1'b0, 1'b0, 8'd2 },  // R2
        '{1'b0, 1'b1, 5'd3,  1'b0, 5'd4,  1'b1, 1'b0, 5'd11, 2'b00, 2'b00, 1'b1, 1'b1, 8'd8 },  // R8
        '{1'b0, 1'b1, 5'd3,  1'b0, 5'd4,  1'b1, 1'b0, 5'd11, 2'b00, 2'b00, 1'b1, 1'b1, 8'd8 },  // R8 load in wb
        '{1'b0, 1'b1, 5'd3,  1'b0, 5'd4,  1'b1, 1'b0, 5'd11, 2'b00, 2'b00, 1'b0, 1'b0, 8'd8 },  // R8 cleared
        '{1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0, 5'd4,  2'b00, 2'b00, 1'b0, 1'b0, 8'd10},  // R10
        '{1'b1, 1'b1, 5'd4,  1'b1, 5'd11, 1'b1, 1'b0, 5'd6,  2'b01, 2'b10, 1'b1, 1'b0, 8'd9 },  // R9
        '{1'b1, 1'b1, 5'd4,  1'b1, 5'd11, 1'b1, 1'b0, 5'd6,  2'b01, 2'b00, 1'b1, 1'b0, 8'd9 },  // R9 wb emptied
        '{1'b0, 1'b1, 5'd4,  1'b1, 5'd11, 1'b1, 1'b0, 5'd6,  2'b01, 2'b00, 1'b0, 1'b0, 8'd9 },  // R9 ex held
        '{1'b0, 1'b1, 5'd4,  1'b1, 5'd6,  1'b0, 1'b0, 5'd0,  2'b10, 2'b01, 1'b0, 1'b0, 8'd10},  // R10
        '{1'b0, 1'b1, 5'd6,  1'b0, 5'd0,  1'b1, 1'b0, 5'd13, 2'b10, 2'b00, 1'b0, 1'b0, 8'd10},  // R10
        '{1'b0, 1'b0, 5'd13, 1'b0, 5'd13, 1'b0, 1'b0, 5'd0,  2'b00, 2'b00, 1'b0, 1'b0, 8'd6 }   // R6
    };

    logic             clk;
    logic             rst_n;
    logic             of_use_a, of_use_b, of_wr, of_ld, mc_busy;
    logic [REG_W-1:0] of_src_a, of_src_b, of_dst;
    logic [1:0]       sel_a, sel_b;
    logic             stall, bubble;

    int checks;
    int errors;
    bit done;

    raw_bypass_ctl #(.REG_W(REG_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .of_use_a_i (of_use_a),
        .of_src_a_i (of_src_a),
        .of_use_b_i (of_use_b),
        .of_src_b_i (of_src_b),
        .of_wr_i    (of_wr),
        .of_ld_i    (of_ld),
        .of_dst_i   (of_dst),
        .mc_busy_i  (mc_busy),
        .sel_a_o    (sel_a),
        .sel_b_o    (sel_b),
        .stall_o    (stall),
        .bubble_o   (bubble)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic drive(input vec_t v);
        mc_busy  = v.busy;
        of_use_a = v.ua;
        of_src_a = v.sa;
        of_use_b = v.ub;
        of_src_b = v.sb;
        of_wr    = v.wr;
        of_ld    = v.ld;
        of_dst   = v.dst;
    endtask

    task automatic check(input int req, input logic [1:0] ea, input logic [1:0] eb,
                         input logic es, input logic eu);
        checks++;
        if (sel_a !== ea || sel_b !== eb || stall !== es || bubble !== eu) begin
            errors++;
            $display("FAIL R%0d: got sel_a=%b sel_b=%b stall=%b bubble=%b, expected %b %b %b %b",
                     req, sel_a, sel_b, stall, bubble, ea, eb, es, eu);
        end
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        drive('0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // stream walk: inputs at the falling edge, outputs checked 2 ns later
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            #2;
            check(int'(VEC[i].req), VEC[i].ea, VEC[i].eb, VEC[i].es, VEC[i].eu);
            @(negedge clk);
        end

        // R1: reset while a producer sits in execute
        drive('{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd12,
                2'b00, 2'b00, 1'b0, 1'b0, 8'd1});
        @(negedge clk);
        drive('{1'b0, 1'b1, 5'd12, 1'b1, 5'd12, 1'b0, 1'b0, 5'd0,
                2'b00, 2'b00, 1'b0, 1'b0, 8'd1});
        #2;
        check(2, 2'b01, 2'b01, 1'b0, 1'b0);   // R2 producer visible before reset
        rst_n = 1'b0;
        #1;
        check(1, 2'b00, 2'b00, 1'b0, 1'b0);   // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(1, 2'b00, 2'b00, 1'b0, 1'b0);   // R1 after release

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule